// File: doc/BRIEF.md
# Zigzag Coefficient Run-Length Tokenizer

This block turns one 8x8 block of quantized transform coefficients, presented in zigzag order, into the symbol stream that an entropy coder consumes. It takes at most one coefficient per clock, on cycles where `en` is high. The first coefficient of each block is the DC term. It leaves the block as a DC token that holds the difference from the DC term of the block before. The 63 AC coefficients that follow become run/value tokens. A run of sixteen zeros becomes a zero-run-extension (ZRL) token. A zero in the last position becomes an end-of-block (EOB) token.

A sequence begins when `start` is high on an enabled cycle while the block is idle. Blocks then follow back to back with no further `start`. The coefficient right after the last AC term of one block is the DC term of the next block. The sequence ends when `last_blk` is high together with the final coefficient of a block. Each token is registered and appears on the cycle after the clock edge that accepted its coefficient. Huffman coding and bit packing are done downstream.

Top module: `rlc_coef_encoder`

## Requirements
- R1: While `rst` (synchronous, active high) is high and on the first cycle after it, `tok_valid` and `tok_blk_end` are 0, and the block is idle.
- R2: In idle, an enabled cycle with `start` high accepts `coef_in` as the first DC term of a sequence. On the next cycle there is a token with `tok_type`=0 (DC), `tok_run`=0 and `tok_value` equal to that coefficient, predicted from zero.
- R3: The DC token of every later block in a sequence carries the current DC minus the previous block's DC as a 13-bit signed value. The next block's DC is the coefficient that follows the 64th coefficient of the block before, with no `start`.
- R4: A zero AC coefficient that is neither the last of its block nor the 16th zero of a run produces no token, and the pending zero run grows by one.
- R5: A nonzero AC coefficient produces `tok_type`=1 (AC). `tok_run` is the number of zeros since the last DC, AC or ZRL token, `tok_value` is the coefficient sign-extended, and the pending run then restarts at zero.
- R6: The 16th consecutive pending zero, when it is not the last of its block, produces `tok_type`=2 (ZRL) with `tok_run`=15 and `tok_value`=0. Counting then restarts from zero.
- R7: If the 64th coefficient is zero, the token is `tok_type`=3 (EOB) with run and value 0. If it is nonzero, the token is an AC token. In both cases `tok_blk_end` is 1, and it is 0 on every other token.
- R8: When `last_blk` is high with the 64th coefficient, the block returns to idle. In idle, coefficients with `start` low produce no token, and the next sequence is again predicted from zero.
- R9: On a cycle with `en` low nothing is accepted, no token appears on the next cycle, and the position and run state are held.
- R10: `start` has no effect while a block is in progress.
- R11: A block is `BLK_LEN` coefficients long (64 by default). Each token appears exactly one cycle after the edge that accepts its coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Accept `coef_in` on this cycle |
| start | input | 1 | Begin a sequence (used only while idle) |
| last_blk | input | 1 | With the final coefficient of a block: end the sequence |
| coef_in | input | CW (12) | Signed coefficient in zigzag order |
| tok_valid | output | 1 | A token is present |
| tok_type | output | 2 | 0 DC, 1 AC, 2 ZRL, 3 EOB |
| tok_run | output | RW (4) | Zero run ahead of the value |
| tok_value | output | CW+1 (13) | Signed DC difference or AC value |
| tok_blk_end | output | 1 | Token closes its block |

## Verification
Every result of this block (a token, the lack of one, the block-end flag) is due exactly one rising edge after the edge that accepted its coefficient. A suppressed zero or a disabled cycle shows up at that same point as `tok_valid` low. The bench changes the inputs on the falling edge and compares all token fields at the next falling edge, one whole register stage later, against a reference model that it advances in lockstep with its own stimulus.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  typedef enum logic [1:0] {
    TOK_DC  = 2'd0,
    TOK_AC  = 2'd1,
    TOK_ZRL = 2'd2,
    TOK_EOB = 2'd3
  } tok_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_DC   = 2'd1,
    SQ_AC   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rlc_pos_counter.sv
// Position of the next coefficient inside the current block.
module rlc_pos_counter #(
  parameter int BLK_LEN = 64,
  localparam int PW = $clog2(BLK_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blk_begin,
  input  logic          step,
  output logic [PW-1:0] pos,
  output logic          at_last
);
  assign at_last = (pos == PW'(BLK_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst)            pos <= '0;
    else if (blk_begin) pos <= PW'(1);
    else if (step)      pos <= at_last ? '0 : pos + 1'b1;
  end

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos <= PW'(BLK_LEN - 1)); // R11
  AST_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && at_last && !blk_begin) |=> (pos == '0)); // R11
endmodule

// File: rtl/rlc_zero_run.sv
// Pending zero-run counter; wraps when a ZRL token is issued.
module rlc_zero_run #(
  parameter int RUN_LIMIT = 16,
  localparam int RW = $clog2(RUN_LIMIT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          zstep,
  output logic [RW-1:0] run,
  output logic          full
);
  assign full = (run == RW'(RUN_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst)        run <= '0;
    else if (clr)   run <= '0;
    else if (zstep) run <= full ? '0 : run + 1'b1;
  end

  AST_RUN_GROWS: assert property (@(posedge clk) disable iff (rst)
    (zstep && !full && !clr) |=> (run == RW'($past(run) + 1'b1))); // R4
  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (rst)
    (zstep && full && !clr) |=> (run == '0)); // R6
endmodule

// File: rtl/rlc_dc_pred.sv
// Previous-DC register and DC difference.
module rlc_dc_pred #(
  parameter int CW = 12,
  localparam int DW = CW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 load,
  input  logic                 from_zero,
  input  logic signed [CW-1:0] coef,
  output logic signed [DW-1:0] diff
);
  logic signed [CW-1:0] prev_q;
  logic signed [DW-1:0] coef_x, base_x;

  always_comb begin
    coef_x = {coef[CW-1], coef};
    base_x = from_zero ? '0 : {prev_q[CW-1], prev_q};
    diff   = coef_x - base_x;
  end

  always_ff @(posedge clk) begin
    if (rst)       prev_q <= '0;
    else if (load) prev_q <= coef;
    else if (clr)  prev_q <= '0;
  end

  AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (rst)
    load |=> (prev_q == $past(coef))); // R3
endmodule

// File: rtl/rlc_seq.sv
// Idle / DC / AC sequencer.
module rlc_seq
  import rlc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic start,
  input  logic last_blk,
  input  logic at_last,
  output logic acc_dc,
  output logic acc_ac,
  output logic idle
);
  seq_state_e st, st_nxt;

  assign idle   = (st == SQ_IDLE);
  assign acc_dc = en && ((idle && start) || (st == SQ_DC));
  assign acc_ac = en && (st == SQ_AC);

  always_comb begin
    st_nxt = st;
    if (acc_dc)                 st_nxt = SQ_AC;
    else if (acc_ac && at_last) st_nxt = last_blk ? SQ_IDLE : SQ_DC;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= SQ_IDLE;
    else     st <= st_nxt;
  end

  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(st)); // R9
  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (acc_ac && at_last && last_blk) |=> idle); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_AC && !(acc_ac && at_last)) |=> (st == SQ_AC)); // R10
endmodule

// File: rtl/rlc_coef_encoder.sv
// Top: DC prediction, AC run coding, ZRL/EOB insertion, registered token.
module rlc_coef_encoder
  import rlc_pkg::*;
#(
  parameter int CW        = 12,
  parameter int BLK_LEN   = 64,
  parameter int RUN_LIMIT = 16,
  localparam int DW = CW + 1,
  localparam int RW = $clog2(RUN_LIMIT),
  localparam int PW = $clog2(BLK_LEN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 start,
  input  logic                 last_blk,
  input  logic signed [CW-1:0] coef_in,
  output logic                 tok_valid,
  output logic [1:0]           tok_type,
  output logic [RW-1:0]        tok_run,
  output logic signed [DW-1:0] tok_value,
  output logic                 tok_blk_end
);
  logic acc_dc, acc_ac, idle, at_last, run_full, coef_zero;
  logic [PW-1:0] pos;
  logic [RW-1:0] run_q;
  logic signed [DW-1:0] dc_diff;

  tok_kind_e            nxt_kind;
  logic [RW-1:0]        nxt_run;
  logic signed [DW-1:0] nxt_val;
  logic                 nxt_fire;

  assign coef_zero = (coef_in == '0);

  rlc_seq u_seq (
    .clk(clk), .rst(rst), .en(en), .start(start), .last_blk(last_blk),
    .at_last(at_last), .acc_dc(acc_dc), .acc_ac(acc_ac), .idle(idle)
  );

  rlc_pos_counter #(.BLK_LEN(BLK_LEN)) u_pos (
    .clk(clk), .rst(rst), .blk_begin(acc_dc), .step(acc_ac),
    .pos(pos), .at_last(at_last)
  );

  rlc_zero_run #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk(clk), .rst(rst),
    .clr(acc_dc || (acc_ac && (!coef_zero || at_last))),
    .zstep(acc_ac && coef_zero && !at_last),
    .run(run_q), .full(run_full)
  );

  rlc_dc_pred #(.CW(CW)) u_dc (
    .clk(clk), .rst(rst), .clr(idle && !acc_dc), .load(acc_dc),
    .from_zero(idle), .coef(coef_in), .diff(dc_diff)
  );

  always_comb begin
    nxt_kind = TOK_DC;
    nxt_run  = '0;
    nxt_val  = dc_diff;
    nxt_fire = 1'b0;
    if (acc_dc) begin
      nxt_fire = 1'b1;
    end else if (acc_ac) begin
      if (!coef_zero) begin
        nxt_kind = TOK_AC;
        nxt_run  = run_q;
        nxt_val  = {coef_in[CW-1], coef_in};
        nxt_fire = 1'b1;
      end else if (at_last) begin
        nxt_kind = TOK_EOB;
        nxt_val  = '0;
        nxt_fire = 1'b1;
      end else if (run_full) begin
        nxt_kind = TOK_ZRL;
        nxt_run  = RW'(RUN_LIMIT - 1);
        nxt_val  = '0;
        nxt_fire = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tok_valid   <= 1'b0;
      tok_type    <= 2'd0;
      tok_run     <= '0;
      tok_value   <= '0;
      tok_blk_end <= 1'b0;
    end else begin
      tok_valid   <= nxt_fire;
      tok_blk_end <= acc_ac && at_last;
      if (nxt_fire) begin
        tok_type  <= nxt_kind;
        tok_run   <= nxt_run;
        tok_value <= nxt_val;
      end
    end
  end

  AST_BLKEND_KIND: assert property (@(posedge clk) disable iff (rst)
    tok_blk_end |-> (tok_valid && (tok_type == TOK_AC || tok_type == TOK_EOB))); // R7
  AST_ZRL_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_type == TOK_ZRL) |-> (tok_run == RW'(RUN_LIMIT - 1) && tok_value == '0)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (idle && !(en && start)) |=> !tok_valid); // R8
  AST_NO_EN_NO_TOKEN: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tok_valid); // R9
  AST_START_TO_DC: assert property (@(posedge clk) disable iff (rst)
    (en && idle && start) |=> (tok_valid && tok_type == TOK_DC && tok_run == '0)); // R2
endmodule

// File: tb/sim_rlc_coef_encoder.sv
module sim_rlc_coef_encoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, start = 1'b0, last_blk = 1'b0;
  logic signed [11:0] coef_in = '0;
  logic tok_valid, tok_blk_end;
  logic [1:0] tok_type;
  logic [3:0] tok_run;
  logic signed [12:0] tok_value;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state: 0 idle, 1 expect DC, 2 in AC
  int m_state = 0, m_prev = 0, m_pos = 0, m_run = 0;
  bit exp_valid, exp_end;
  logic [1:0] exp_type;
  logic [3:0] exp_run;
  logic signed [12:0] exp_val;
  string tag;

  always #2 clk = ~clk;

  rlc_coef_encoder u0 (
    .clk(clk), .rst(rst), .en(en), .start(start), .last_blk(last_blk),
    .coef_in(coef_in), .tok_valid(tok_valid), .tok_type(tok_type),
    .tok_run(tok_run), .tok_value(tok_value), .tok_blk_end(tok_blk_end)
  );

  task automatic model_step(bit e, bit st, bit lb, logic signed [11:0] c);
    int ci = int'(c);
    bit last;
    exp_valid = 0; exp_end = 0; exp_type = 0; exp_run = 0; exp_val = 0;
    tag = !e ? "R9" : (m_state == 0 ? "R8" : "R4");
    if (!e) return;
    if (m_state == 0 || m_state == 1) begin
      if (m_state == 0 && !st) return;
      tag = (m_state == 0) ? "R2" : "R3";
      exp_valid = 1; exp_type = 2'd0;
      exp_val = 13'(ci - ((m_state == 0) ? 0 : m_prev));
      m_prev = ci; m_pos = 1; m_run = 0; m_state = 2;
    end else begin
      last = (m_pos == 63);
      if (ci != 0) begin
        tag = last ? "R7" : "R5";
        exp_valid = 1; exp_type = 2'd1; exp_run = 4'(m_run);
        exp_val = 13'(ci); exp_end = last; m_run = 0;
      end else if (last) begin
        tag = "R7";
        exp_valid = 1; exp_type = 2'd3; exp_end = 1; m_run = 0;
      end else if (m_run == 15) begin
        tag = "R6";
        exp_valid = 1; exp_type = 2'd2; exp_run = 4'd15; m_run = 0;
      end else begin
        m_run++;
      end
      m_pos = last ? 0 : m_pos + 1;
      if (last) m_state = lb ? 0 : 1;
    end
  endtask

  task automatic drive(bit e, bit st, bit lb, logic signed [11:0] c);
    en = e; start = st; last_blk = lb; coef_in = c;
    model_step(e, st, lb, c);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (tok_valid !== exp_valid || tok_blk_end !== exp_end ||
        (exp_valid && (tok_type !== exp_type || tok_run !== exp_run || tok_value !== exp_val))) begin
      errors++;
      $display("FAIL %s: got v=%0b t=%0d r=%0d val=%0d end=%0b, expected v=%0b t=%0d r=%0d val=%0d end=%0b",
               tag, tok_valid, tok_type, tok_run, tok_value, tok_blk_end,
               exp_valid, exp_type, exp_run, exp_val, exp_end);
    end
  endtask

  function automatic logic signed [11:0] rand_coef(int dens);
    if (dens == 0) return '0;
    if (($urandom % 60) == 0) return -12'sd2048;
    if (int'($urandom % 4) < dens) return 12'($urandom);
    return '0;
  endfunction

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    checks++;
    if (tok_valid !== 1'b0 || tok_blk_end !== 1'b0) begin
      errors++;
      $display("FAIL R1: got v=%0b end=%0b, expected 0 0", tok_valid, tok_blk_end);
    end
    rst = 1'b0;
    checks++;
    if (tok_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: got v=%0b after reset, expected 0", tok_valid);
    end

    // R2: first DC, then an all-zero block: ZRL x3 (R6), EOB (R7)
    drive(1, 1, 0, 12'sd100);
    for (int i = 1; i < 64; i++) drive(1, 0, 0, '0);

    // R3: next block without start; R9 gaps, R10 stray start, R5 runs, R7 nonzero last
    drive(1, 0, 0, -12'sd50);
    drive(0, 1, 0, 12'sd77);
    for (int i = 1; i < 64; i++) begin
      logic signed [11:0] v;
      v = (i == 1) ? 12'sd5 : (i == 20) ? -12'sd2048 : (i == 40) ? 12'sd2047 : (i == 63) ? -12'sd3 : '0;
      if (i == 30) drive(0, 0, 0, 12'sd9);
      drive(1, (i % 7) == 0, i == 63, v);
    end

    // R8: idle ignores coefficients without start; R9 start with en low
    for (int i = 0; i < 5; i++) drive(1, 0, 0, 12'sd33);
    drive(0, 1, 0, 12'sd33);
    // R8: fresh sequence predicted from zero, then extreme DC step (R3)
    drive(1, 1, 0, 12'sd2047);
    for (int i = 1; i < 64; i++) drive(1, 0, 0, (i % 17 == 0) ? 12'sd1 : '0);
    drive(1, 0, 0, -12'sd2048);
    for (int i = 1; i < 64; i++) drive(1, 0, i == 63, '0);

    // random phase
    begin
      int dens = 2;
      for (int n = 0; n < 4000; n++) begin
        if (n % 64 == 0) dens = int'($urandom % 4);
        drive(($urandom % 6) != 0, ($urandom % 3) == 0, ($urandom % 4) == 0, rand_coef(dens));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected end of stimulus");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule